// File: doc/BRIEF.md
# Code-Selected Reference Frequency Divider

This block divides a crystal-derived reference clock by one of eight fixed ratios and produces the comparison-rate pulse that a phase detector uses as its reference input. A 3-bit code, normally strapped on the board, picks the ratio from a fixed set of mixed values. Some of these values are powers of two and some are not. For example, a 6.4 MHz clock with code 011 gives a 25 kHz reference.

Inside, a down-counter is loaded with ratio minus one and counts to zero. At zero it reloads and raises a registered output pulse for one clock. The block reads the select code only at that terminal count. A code change therefore never shortens or stretches the period already under way. The new ratio applies from the next period. A registered copy of the ratio now in force is also provided.

Top module: `ref_rate_divider`

## Requirements
- R1: Code to ratio mapping: 000→8, 001→64, 010→128, 011→256, 100→540, 101→1000, 110→1024, 111→2048.
- R2: With a constant code, the distance between successive rising edges of `ref_pulse_o` is exactly the selected ratio in clock cycles.
- R3: `ref_pulse_o` is high for exactly one clock cycle per period.
- R4: `ratio_o` shows the ratio of the period now running and changes only in the cycle in which `ref_pulse_o` goes high.
- R5: While `rst` is high (synchronous, active high), `ref_pulse_o` is low and `ratio_o` equals the ratio of the current code. The first pulse comes exactly one ratio of cycles after the last reset edge.
- R6: A code change in the middle of a period does not alter that period. The period that starts at the next terminal count uses the new ratio.
- R7: A code change that is undone before the terminal count has no effect on any period.
- R8: With a 6.4 MHz clock and code 011, the pulse rate is 25 kHz (6,400,000 / interval = 25,000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Ratio select code |
| ref_pulse_o | output | 1 | One-cycle reference pulse, once per period |
| ratio_o | output | 12 | Ratio in force for the current period |

## Verification
The assertions check several properties on every cycle. The pulse never lasts longer than one clock. `ratio_o` always holds one of the eight legal values and moves only together with a pulse. The gap between pulses always equals the ratio that was in force, and each new ratio matches the code present at the terminal count. Some behaviours can be shown only by the bench's scenarios. These are the exact periods for every code, the first pulse after reset, the timing of a mid-period change, a change that is undone before it takes effect, and the 25 kHz result.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = 11;
  localparam int RATIO_W = CNT_W + 1;
  localparam int N_CODES = 1 << SEL_W;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = RATIO_W'(8);
      3'd1:    r = RATIO_W'(64);
      3'd2:    r = RATIO_W'(128);
      3'd3:    r = RATIO_W'(256);
      3'd4:    r = RATIO_W'(540);
      3'd5:    r = RATIO_W'(1000);
      3'd6:    r = RATIO_W'(1024);
      default: r = RATIO_W'(2048);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/refdiv_ratio_lut.sv
module refdiv_ratio_lut
  import refdiv_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W,
  localparam int RW = CW + 1
) (
  input  logic [SW-1:0] sel,
  output logic [RW-1:0] ratio,
  output logic [CW-1:0] reload
);
  logic [RW-1:0] table_q [N_CODES];
  logic [RW-1:0] minus_one;

  for (genvar g = 0; g < N_CODES; g++) begin : g_entry
    assign table_q[g] = ratio_of(SEL_W'(g));
  end

  always_comb begin
    ratio     = table_q[sel];
    minus_one = ratio - RW'(1);
    reload    = minus_one[CW-1:0];
  end
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CW = refdiv_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] reload,
  output logic          tc
);
  logic [CW-1:0] cnt_q;

  assign tc = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || tc) cnt_q <= reload;
    else           cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/refdiv_outreg.sv
module refdiv_outreg #(
  parameter int RW = refdiv_pkg::RATIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tc,
  input  logic [RW-1:0] ratio_next,
  output logic          pulse,
  output logic [RW-1:0] ratio_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse     <= 1'b0;
      ratio_act <= ratio_next;
    end else begin
      pulse <= tc;
      if (tc) ratio_act <= ratio_next;
    end
  end
endmodule

// File: rtl/ref_rate_divider.sv
module ref_rate_divider
  import refdiv_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W,
  localparam int RW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel_i,
  output logic          ref_pulse_o,
  output logic [RW-1:0] ratio_o
);
  logic [RW-1:0] lut_ratio;
  logic [CW-1:0] lut_reload;
  logic          term;

  refdiv_ratio_lut #(.SW(SW), .CW(CW)) u_lut (
    .sel    (sel_i),
    .ratio  (lut_ratio),
    .reload (lut_reload)
  );

  refdiv_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .reload (lut_reload),
    .tc     (term)
  );

  refdiv_outreg #(.RW(RW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .tc         (term),
    .ratio_next (lut_ratio),
    .pulse      (ref_pulse_o),
    .ratio_act  (ratio_o)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int RW = RATIO_W
) (
  input logic          clk,
  input logic          rst,
  input logic [SW-1:0] sel_i,
  input logic          ref_pulse_o,
  input logic [RW-1:0] ratio_o
);
  logic          armed;
  logic [RW+1:0] gap;

  always_ff @(posedge clk) begin
    armed <= !rst;
    if (rst)              gap <= '0;
    else if (ref_pulse_o) gap <= (RW+2)'(1);
    else                  gap <= gap + (RW+2)'(1);
  end

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    ref_pulse_o |=> !ref_pulse_o);

  assert_ratio_legal_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    ratio_o inside {RW'(8), RW'(64), RW'(128), RW'(256), RW'(540), RW'(1000), RW'(1024), RW'(2048)});

  assert_ratio_moves_with_pulse_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    !$stable(ratio_o) |-> ref_pulse_o);

  assert_interval_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    ref_pulse_o |-> (gap == (RW+2)'($past(ratio_o))));

  assert_code_at_terminal_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    ref_pulse_o |-> (ratio_o == ratio_of($past(sel_i))));
endmodule

bind ref_rate_divider refdiv_checker #(.SW(SW), .RW(RW)) u_refdiv_chk (
  .clk         (clk),
  .rst         (rst),
  .sel_i       (sel_i),
  .ref_pulse_o (ref_pulse_o),
  .ratio_o     (ratio_o)
);

// File: tb/test_ref_rate_divider.sv
`timescale 1ns/1ps
module test_ref_rate_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sel = 3'd0;
  logic        pulse;
  logic [11:0] ratio;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 0;

  always #10 clk = ~clk;

  ref_rate_divider i_ref_rate_divider (
    .clk(clk), .rst(rst), .sel_i(sel), .ref_pulse_o(pulse), .ratio_o(ratio)
  );

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 8;    1: return 64;   2: return 128;  3: return 256;
      4: return 540;  5: return 1000; 6: return 1024; default: return 2048;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // counts negedges until pulse seen; optionally changes sel after chg_at edges
  task automatic wait_pulse(output int n, input int chg_at = -1, input logic [2:0] nsel = 3'd0,
                            input int back_at = -1, input logic [2:0] bsel = 3'd0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == chg_at)  sel = nsel;
      if (n == back_at) sel = bsel;
    end while (!pulse);
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst = 1'b1;
    sel = code;
    repeat (3) @(negedge clk);
    chk("R5 reset pulse low", int'(pulse), 0);
    chk("R5 reset ratio", int'(ratio), exp_ratio(int'(code)));
    rst = 1'b0;
  endtask

  initial begin
    int n;
    int n2;
    // R5 / R1: reset state for every code
    for (int c = 0; c < 8; c++) do_reset(3'(c));

    // R1, R2, R3, R5: sweep all codes
    for (int c = 0; c < 8; c++) begin
      do_reset(3'(c));
      wait_pulse(n);
      chk($sformatf("R5 first interval code %0d", c), n, exp_ratio(c));
      chk($sformatf("R1 ratio_o code %0d", c), int'(ratio), exp_ratio(c));
      for (int k = 0; k < 2; k++) begin
        wait_pulse(n);
        chk($sformatf("R2 interval code %0d", c), n, exp_ratio(c));
        if (c == 3) chk("R8 25 kHz from 6.4 MHz", 6400000 / n, 25000);
      end
      @(negedge clk);
      chk("R3 pulse one cycle", int'(pulse), 0);
    end

    // R6: short to long, change mid-period
    do_reset(3'd0);
    wait_pulse(n);
    wait_pulse(n, 3, 3'd2);
    chk("R6 ongoing period keeps old ratio", n, 8);
    chk("R4 ratio_o updated at pulse", int'(ratio), 128);
    wait_pulse(n);
    chk("R6 next period uses new ratio", n, 128);

    // R6: long to short
    do_reset(3'd7);
    wait_pulse(n, 1000, 3'd0);
    chk("R6 ongoing long period", n, 2048);
    wait_pulse(n);
    chk("R6 short after long", n, 8);

    // R4: ratio_o stable mid-period while code differs
    do_reset(3'd4);
    wait_pulse(n);
    wait_pulse(n, 100, 3'd1);
    chk("R6 540 period kept", n, 540);
    repeat (10) @(negedge clk);
    chk("R4 ratio_o stable mid-period", int'(ratio), 64);
    sel = 3'd5;
    repeat (5) @(negedge clk);
    chk("R4 ratio_o unchanged before terminal", int'(ratio), 64);
    wait_pulse(n2);
    wait_pulse(n);
    chk("R6 new ratio after change", n, 1000);

    // R7: change undone before terminal count
    do_reset(3'd2);
    wait_pulse(n);
    wait_pulse(n, 20, 3'd6, 60, 3'd2);
    chk("R7 reverted change, current", n, 128);
    chk("R7 reverted change, ratio_o", int'(ratio), 128);
    wait_pulse(n);
    chk("R7 reverted change, next", n, 128);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule